// File: doc/BRIEF.md
# Serial OSD Command Receiver

This block sits behind a three-wire serial port (active-low select, clock, data). It assembles incoming bits into bytes and turns them into updates of the on-screen display state. A byte with its top bit set opens a command. The command stays in force, so any number of data bytes can follow it. Depending on the command, a byte loads the write address of a 12-line by 24-column character memory, loads the vertical or horizontal size and start position, or produces a write strobe for one of the extended control registers.

One command switches the port into a locked character mode. In that mode every byte, whatever its top bit, is stored in the character memory as an attribute flag plus a 7-bit character code. The column then steps forward, and at the end of a line it wraps to column 0 of the next line. Only releasing the select line leaves this mode. Releasing it also puts the command state back to address setup. All serial inputs are brought into the system clock domain with a short synchronizer chain before use.

Top module: `osd_cmd_rx`

## Requirements
- R1: After reset, cur_cmd reads 4'b1000 (address setup), mem_we and ext_we are 0, and every size, position, address and data output is 0.
- R2: Bits are taken most significant first, on rising sclk edges seen while cs_n is low. Edges while cs_n is high are ignored. Raising cs_n discards a partly received byte, and the next byte starts at bit 7.
- R3: A received byte with bit 7 = 1 is a command byte, and cur_cmd takes its bits 7:4. That code then governs every following byte with bit 7 = 0 until another command byte arrives.
- R4: Command byte 1000_LLLL sets the write line to LLLL. A data byte 000C_CCCC under that command sets the write column to CCCCC.
- R5: Command byte 1001_0000 locks character mode. Each later byte, including one with bit 7 = 1, gives a one-cycle mem_we with mem_data equal to the byte (bit 7 attribute, bits 6:0 code) at the current line and column, and cur_cmd stays 4'b1001.
- R6: After each character byte the column increments. Column 23 wraps to column 0, and the line then increments.
- R7: When the line is above 11 or the column is above 23, a character byte gives no mem_we, but the address still advances.
- R8: Raising cs_n ends character mode and returns cur_cmd to 4'b1000. The line and column are kept.
- R9: Command byte 1010_SSSS loads vsize, and its data bytes load vpos from bits 6:0. Command byte 1011_SSSS loads hsize, and its data bytes load hpos from bits 5:0.
- R10: Command bytes 1100, 1101 and 1110 (any low nibble) select registers 4, 5 and 6. Command byte 1111_nnnn selects register 7+n. Each data byte then pulses ext_we for one cycle, with ext_id set to the register number and ext_data set to bits 6:0. For n above 10 there is no pulse.
- R11: A command byte 1001_xxxx with a nonzero low nibble does not lock character mode, so the next byte with bit 7 = 1 is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, sampled on rising edge |
| sdi | input | 1 | Serial data, MSB first |
| cur_cmd | output | 4 | Command code currently in force |
| mem_we | output | 1 | Character memory write strobe |
| mem_line | output | 4 | Character memory line of the write |
| mem_col | output | 5 | Character memory column of the write |
| mem_data | output | 8 | Attribute bit and character code |
| vsize | output | 4 | Vertical character size |
| vpos | output | 7 | Vertical start field |
| hsize | output | 4 | Horizontal character size |
| hpos | output | 6 | Horizontal start position |
| ext_we | output | 1 | Extended control register write strobe |
| ext_id | output | 5 | Extended register number (4 to 17) |
| ext_data | output | 7 | Extended register data |

## Verification
Character writes are run three ways: from a mid-line address, across the end of a line, and at and beyond the last valid line and column. Together these separate the plain store, the wrap into the next line and the suppression of the strobe. A byte with bit 7 set is sent inside locked mode to show that it is stored rather than decoded. The same kind of byte sent after a select release must be decoded, which shows the lock is gone. Sticky commands are tested by sending several data bytes after one command byte. Bit alignment is tested with clock edges given while deselected and with a partial byte cut short by a select release. In both cases the next whole byte must land intact.

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx #(
  parameter int LINES = 12,
  parameter int COLS = 24,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_MAX_SEL = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic [3:0] cur_cmd,
  output logic       mem_we,
  output logic [3:0] mem_line,
  output logic [4:0] mem_col,
  output logic [7:0] mem_data,
  output logic [3:0] vsize,
  output logic [6:0] vpos,
  output logic [3:0] hsize,
  output logic [5:0] hpos,
  output logic       ext_we,
  output logic [4:0] ext_id,
  output logic [6:0] ext_data
);
  localparam logic [3:0] LAST_LINE = 4'(LINES - 1);
  localparam logic [4:0] LAST_COL = 5'(COLS - 1);
  localparam logic [3:0] SEL_MAX = 4'(EXT_MAX_SEL);

  logic [SYNC_STAGES-1:0] cs_p, sd_p;
  logic [SYNC_STAGES:0]   sck_p;
  logic       cs_s, sd_s, sck_rise;
  logic [6:0] shreg;
  logic [2:0] bitcnt;
  logic [2:0] cmd;
  logic [3:0] sel;
  logic       locked;
  logic [3:0] line;
  logic [4:0] col;
  logic [7:0] rx;

  assign cs_s     = cs_p[SYNC_STAGES-1];
  assign sd_s     = sd_p[SYNC_STAGES-1];
  assign sck_rise = sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
  assign rx       = {shreg, sd_s};
  assign cur_cmd  = {1'b1, cmd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p     <= '1;
      sck_p    <= '1;
      sd_p     <= '0;
      shreg    <= '0;
      bitcnt   <= '0;
      cmd      <= '0;
      sel      <= '0;
      locked   <= 1'b0;
      line     <= '0;
      col      <= '0;
      mem_we   <= 1'b0;
      mem_line <= '0;
      mem_col  <= '0;
      mem_data <= '0;
      vsize    <= '0;
      vpos     <= '0;
      hsize    <= '0;
      hpos     <= '0;
      ext_we   <= 1'b0;
      ext_id   <= '0;
      ext_data <= '0;
    end else begin
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      sd_p   <= {sd_p[SYNC_STAGES-2:0], sdi};
      sck_p  <= {sck_p[SYNC_STAGES-1:0], sclk};
      mem_we <= 1'b0;
      ext_we <= 1'b0;
      if (cs_s) begin
        bitcnt <= '0;
        cmd    <= '0;
        locked <= 1'b0;
      end else if (sck_rise) begin
        shreg  <= rx[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (locked) begin
            mem_we   <= (line <= LAST_LINE) && (col <= LAST_COL);
            mem_line <= line;
            mem_col  <= col;
            mem_data <= rx;
            if (col == LAST_COL) begin
              col  <= '0;
              line <= line + 4'd1;
            end else begin
              col <= col + 5'd1;
            end
          end else if (rx[7]) begin
            cmd <= rx[6:4];
            sel <= rx[3:0];
            case (rx[6:4])
              3'd0: line   <= rx[3:0];
              3'd1: locked <= (rx[3:0] == 4'd0);
              3'd2: vsize  <= rx[3:0];
              3'd3: hsize  <= rx[3:0];
              default: ;
            endcase
          end else begin
            case (cmd)
              3'd0: col  <= rx[4:0];
              3'd2: vpos <= rx[6:0];
              3'd3: hpos <= rx[5:0];
              3'd4, 3'd5, 3'd6: begin
                ext_we   <= 1'b1;
                ext_id   <= {2'b00, cmd};
                ext_data <= rx[6:0];
              end
              3'd7: begin
                ext_we   <= (sel <= SEL_MAX);
                ext_id   <= 5'd7 + {1'b0, sel};
                ext_data <= rx[6:0];
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/osd_cmd_rx_chk.sv
module osd_cmd_rx_chk #(
  parameter int LINES = 12,
  parameter int COLS = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [3:0] cur_cmd,
  input logic       mem_we,
  input logic [3:0] mem_line,
  input logic [4:0] mem_col,
  input logic       ext_we,
  input logic [4:0] ext_id
);
  localparam logic [3:0] LAST_LINE = 4'(LINES - 1);
  localparam logic [4:0] LAST_COL = 5'(COLS - 1);

  assert_we_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_line <= LAST_LINE) && (mem_col <= LAST_COL));

  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> (cur_cmd == 4'b1000) && !mem_we && !ext_we);

  assert_ext_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (ext_id >= 5'd4) && (ext_id <= 5'd17));

  assert_ext_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |=> !ext_we);
endmodule

bind osd_cmd_rx osd_cmd_rx_chk #(.LINES(LINES), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cur_cmd(cur_cmd),
  .mem_we(mem_we), .mem_line(mem_line), .mem_col(mem_col),
  .ext_we(ext_we), .ext_id(ext_id)
);

// File: tb/sim_osd_cmd_rx.sv
module sim_osd_cmd_rx;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [3:0] cur_cmd, mem_line, vsize, hsize;
  logic [4:0] mem_col, ext_id;
  logic [7:0] mem_data;
  logic [6:0] vpos, ext_data;
  logic [5:0] hpos;
  logic mem_we, ext_we;

  int checks = 0, fails = 0;
  int wr_n = 0, wl = 0, wc = 0, wd = 0;
  int ex_n = 0, eid = 0, edat = 0;

  always #5 clk = ~clk;

  osd_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cur_cmd(cur_cmd), .mem_we(mem_we), .mem_line(mem_line), .mem_col(mem_col),
    .mem_data(mem_data), .vsize(vsize), .vpos(vpos), .hsize(hsize), .hpos(hpos),
    .ext_we(ext_we), .ext_id(ext_id), .ext_data(ext_data)
  );

  always @(negedge clk) begin
    if (mem_we) begin wr_n++; wl = mem_line; wc = mem_col; wd = mem_data; end
    if (ext_we) begin ex_n++; eid = ext_id; edat = ext_data; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sclk = 1'b0; sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic cs_lo; cs_n = 1'b0; repeat (4) @(negedge clk); endtask
  task automatic cs_hi; cs_n = 1'b1; repeat (6) @(negedge clk); endtask

  task automatic t_reset;
    chk("R1 cur_cmd", cur_cmd, 4'b1000);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 ext_we", ext_we, 0);
    chk("R1 sizes", {vsize, hsize}, 0);
    chk("R1 positions", {vpos, hpos, mem_line, mem_col, mem_data, ext_id, ext_data}, 0);
  endtask

  task automatic t_addr_lock;
    int n0;
    cs_lo; send(8'h83); send(8'h05);
    chk("R3 cmd after data", cur_cmd, 4'b1000);
    send(8'h90);
    chk("R5 lock cmd", cur_cmd, 4'b1001);
    n0 = wr_n;
    send(8'h41);
    chk("R4 R5 count", wr_n - n0, 1);
    chk("R4 line", wl, 3); chk("R4 col", wc, 5); chk("R5 data", wd, 8'h41);
    send(8'hC2);
    chk("R5 bit7 byte stored", wr_n - n0, 2);
    chk("R5 data C2", wd, 8'hC2); chk("R6 col step", wc, 6);
    chk("R5 still locked", cur_cmd, 4'b1001);
    cs_hi;
    chk("R8 release cmd", cur_cmd, 4'b1000);
  endtask

  task automatic t_wrap;
    cs_lo; send(8'h81); send(8'h16); send(8'h90);
    send(8'h10); chk("R6 col22", wc, 22);
    send(8'h11); chk("R6 col23 line", {wl, wc}, {1, 23});
    send(8'h12); chk("R6 wrap line", wl, 2); chk("R6 wrap col", wc, 0);
    chk("R6 wrap data", wd, 8'h12);
    cs_hi;
  endtask

  task automatic t_range;
    int n0;
    cs_lo; send(8'h8B); send(8'h17); send(8'h90);
    n0 = wr_n;
    send(8'h20); chk("R7 last cell written", wr_n - n0, 1);
    chk("R7 last cell addr", {wl, wc}, {11, 23});
    send(8'h21); chk("R7 line 12 suppressed", wr_n - n0, 1);
    cs_hi;
    cs_lo; send(8'h8E); send(8'h00); send(8'h90); send(8'h22);
    chk("R7 line 14 suppressed", wr_n - n0, 1);
    cs_hi;
    cs_lo; send(8'h80); send(8'h19); send(8'h90); send(8'h23); send(8'h24);
    chk("R7 col 25 26 suppressed", wr_n - n0, 1);
    cs_hi;
  endtask

  task automatic t_pos;
    cs_lo; send(8'hA5); send(8'h45);
    chk("R9 vsize", vsize, 5); chk("R9 vpos", vpos, 7'h45);
    send(8'hB2); send(8'h3F); send(8'h21);
    chk("R9 hsize", hsize, 2); chk("R3 R9 sticky hpos", hpos, 6'h21);
    cs_hi;
  endtask

  task automatic t_release;
    int n0;
    cs_lo; send(8'h80); send(8'h00); send(8'h90); send(8'h30);
    cs_hi;
    n0 = wr_n;
    cs_lo; send(8'hA3);
    chk("R8 decoded after release", vsize, 3);
    chk("R8 no write after release", wr_n - n0, 0);
    chk("R8 cmd", cur_cmd, 4'b1010);
    cs_hi;
  endtask

  task automatic t_ext;
    int n0;
    n0 = ex_n;
    cs_lo; send(8'hF3); send(8'h55);
    chk("R10 ext count", ex_n - n0, 1);
    chk("R10 ext id 10", eid, 10); chk("R10 ext data", edat, 8'h55);
    send(8'h56);
    chk("R10 sticky ext", ex_n - n0, 2); chk("R10 data 56", edat, 8'h56);
    send(8'hD7); send(8'h12);
    chk("R10 id 5", eid, 5); chk("R10 data 12", edat, 8'h12);
    send(8'hFC); send(8'h11);
    chk("R10 sel 12 no pulse", ex_n - n0, 3);
    send(8'hC0); send(8'h01);
    chk("R10 id 4", eid, 4);
    cs_hi;
  endtask

  task automatic t_bits;
    send(8'hA9);
    chk("R2 deselected edges ignored", vsize, 3);
    cs_lo; bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    cs_hi;
    cs_lo; send(8'hA6); send(8'h0F);
    chk("R2 realigned vsize", vsize, 6); chk("R2 realigned vpos", vpos, 7'h0F);
    cs_hi;
  endtask

  task automatic t_nolock;
    int n0;
    n0 = wr_n;
    cs_lo; send(8'h91);
    chk("R11 cmd 1001", cur_cmd, 4'b1001);
    send(8'h82);
    chk("R11 not locked", cur_cmd, 4'b1000);
    chk("R11 no write", wr_n - n0, 0);
    cs_hi;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary;
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_addr_lock;
    t_wrap;
    t_range;
    t_pos;
    t_release;
    t_ext;
    t_bits;
    t_nolock;
    summary;
    $finish;
  end
endmodule